// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links two parallel buses, A and B. Each transfer direction has its own storage register, its own capture strobe, its own output enable and its own source select. A direction can pass the live value of the opposite bus across, or it can drive the word held in its register. This covers live transfer, store, and later replay, independently in each direction. A parameter makes both paths true or inverting.

Each bus is split into an input vector, an output vector and an output-enable bit. An extra input per bus tells the block whether some other agent is driving that bus. The block samples all inputs on one system clock `clk`. Capture strobes are edge-detected on that clock. Both outputs come from flip-flops, so a change of select can never produce a hazard at the pins.

When no agent drives a bus, a holding register keeps the bus value the block last saw. This includes a value the block drove onto the bus itself. With both directions enabled in live mode and no outside drivers, the two buses therefore keep their last common value.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both storage registers, both data outputs and both output enables are 0.
- R2: The A-to-B register loads the A bus value on the first `clk` edge that sees `cap_ab` high after it was low. The B-to-A register does the same from the B bus on `cap_ba`. Loading happens whatever the selects and enables are. A strobe held high loads only once.
- R3: With `sel_ab` = 0, `b_out` shows the A bus value sampled at the previous `clk` edge. With `sel_ba` = 0, `a_out` shows the B bus value in the same way.
- R4: With `sel_ab` = 1, `b_out` shows the A-to-B register contents as they stood at the previous edge. With `sel_ba` = 1, `a_out` shows the B-to-A register contents in the same way.
- R5: `b_oe` follows `oe_ab`, which is active high, one cycle later. `a_oe` follows `oe_ba_n`, which is active low, one cycle later. Both directions can therefore be on at once or off at once.
- R6: With INVERT = 1, each data output is the bitwise complement of the value R3 or R4 selects. With INVERT = 0, the value passes unchanged.
- R7: When a select changes, the output changes in a single cycle from the old source's value to the new one, with no value in between.
- R8: The value seen on a bus comes from one of three sources, in this order of priority: the bus input when the external-drive flag is 1; otherwise the block's own output on that bus while its enable is 1; otherwise the last value seen on that bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | WIDTH | Value on the A bus from outside agents |
| a_ext | input | 1 | 1 when an outside agent drives the A bus |
| a_out | output | WIDTH | Data the block drives onto A |
| a_oe | output | 1 | Drive enable for `a_out` |
| b_in | input | WIDTH | Value on the B bus from outside agents |
| b_ext | input | 1 | 1 when an outside agent drives the B bus |
| b_out | output | WIDTH | Data the block drives onto B |
| b_oe | output | 1 | Drive enable for `b_out` |
| cap_ab | input | 1 | Capture strobe for the A-to-B register, rising edge |
| cap_ba | input | 1 | Capture strobe for the B-to-A register, rising edge |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored word |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored word |
| oe_ab | input | 1 | Enable B drive, active high |
| oe_ba_n | input | 1 | Enable A drive, active low |

## Verification
A storage register that loaded at the wrong time, or missed a load, is invisible while its direction is in live mode. It only shows up in the first cycle after its select goes to 1. For that reason the bench loads words while the outputs are disabled and while a strobe is held high, and then reads them back in stored mode. A wrong bus-hold register shows up in the cycle after the outside drivers stop driving: the opposite output then jumps away from the last common value.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic             a_ext,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_ext,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             oe_ab,
  input  logic             oe_ba_n
);
  localparam logic [WIDTH-1:0] FLIP = INVERT ? '1 : '0;

  logic [WIDTH-1:0] st_ab, st_ba, a_hold, b_hold, a_bus, b_bus;
  logic             cap_ab_q, cap_ba_q, live;
  logic             ld_ab, ld_ba;

  assign a_bus = a_ext ? a_in : (a_oe ? a_out : a_hold);
  assign b_bus = b_ext ? b_in : (b_oe ? b_out : b_hold);
  assign ld_ab = cap_ab & ~cap_ab_q;
  assign ld_ba = cap_ba & ~cap_ba_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ab    <= '0;
      st_ba    <= '0;
      a_hold   <= '0;
      b_hold   <= '0;
      a_out    <= '0;
      b_out    <= '0;
      a_oe     <= 1'b0;
      b_oe     <= 1'b0;
      cap_ab_q <= 1'b0;
      cap_ba_q <= 1'b0;
      live     <= 1'b0;
    end else begin
      cap_ab_q <= cap_ab;
      cap_ba_q <= cap_ba;
      if (ld_ab) st_ab <= a_bus;
      if (ld_ba) st_ba <= b_bus;
      a_hold <= a_bus;
      b_hold <= b_bus;
      b_out  <= (sel_ab ? st_ab : a_bus) ^ FLIP;
      a_out  <= (sel_ba ? st_ba : b_bus) ^ FLIP;
      b_oe   <= oe_ab;
      a_oe   <= ~oe_ba_n;
      live   <= 1'b1;
    end
  end

  a_r2_load_ab: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(ld_ab) |-> st_ab == $past(a_bus));
  a_r2_keep_ab: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(ld_ab) |-> $stable(st_ab));
  a_r2_load_ba: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(ld_ba) |-> st_ba == $past(b_bus));
  a_r2_keep_ba: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(ld_ba) |-> $stable(st_ba));
  a_r3_live_b: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(sel_ab) |-> b_out == ($past(a_bus) ^ FLIP));
  a_r3_live_a: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(sel_ba) |-> a_out == ($past(b_bus) ^ FLIP));
  a_r4_replay_b: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(sel_ab) |-> b_out == ($past(st_ab) ^ FLIP));
  a_r4_replay_a: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(sel_ba) |-> a_out == ($past(st_ba) ^ FLIP));
  a_r5_enables: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> b_oe == $past(oe_ab) && a_oe == !$past(oe_ba_n));
  a_r8_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    live && !a_ext && !a_oe |-> a_bus == $past(a_bus));
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] a_in = '0, b_in = '0;
  logic       a_ext = 1'b0, b_ext = 1'b0;
  logic       cap_ab = 1'b0, cap_ba = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic       oe_ab = 1'b0, oe_ba_n = 1'b1;
  logic [7:0] a_out, b_out, a_out_i, b_out_i;
  logic       a_oe, b_oe, a_oe_i, b_oe_i;
  int         checks = 0, fails = 0;

  typedef struct {
    logic [7:0] bo; logic boe; logic [7:0] ao; logic aoe; bit inv; string req;
  } item_t;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  bus_xcvr_reg #(.WIDTH(8), .INVERT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_oe(b_oe), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n));

  bus_xcvr_reg #(.WIDTH(8), .INVERT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ext(a_ext), .a_out(a_out_i), .a_oe(a_oe_i),
    .b_in(b_in), .b_ext(b_ext), .b_out(b_out_i), .b_oe(b_oe_i), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n));

  task automatic step(input logic [7:0] a, input logic ae, input logic [7:0] b, input logic be,
                      input logic sab, input logic sba, input logic oab, input logic oban,
                      input logic cab, input logic cba,
                      input logic [7:0] xbo, input logic xboe, input logic [7:0] xao, input logic xaoe,
                      input bit inv, input string req);
    item_t it;
    @(negedge clk);
    a_in = a; a_ext = ae; b_in = b; b_ext = be;
    sel_ab = sab; sel_ba = sba; oe_ab = oab; oe_ba_n = oban; cap_ab = cab; cap_ba = cba;
    it.bo = xbo; it.boe = xboe; it.ao = xao; it.aoe = xaoe; it.inv = inv; it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (b_out !== it.bo || b_oe !== it.boe || a_out !== it.ao || a_oe !== it.aoe) begin
          fails++;
          $display("FAIL %s: b_out=%h b_oe=%b a_out=%h a_oe=%b expected %h %b %h %b",
                   it.req, b_out, b_oe, a_out, a_oe, it.bo, it.boe, it.ao, it.aoe);
        end
        if (it.inv) begin
          checks++;
          if (b_out_i !== ~it.bo || a_out_i !== ~it.ao || b_oe_i !== it.boe || a_oe_i !== it.aoe) begin
            fails++;
            $display("FAIL R6 (%s, inverting): b_out=%h a_out=%h expected %h %h",
                     it.req, b_out_i, a_out_i, ~it.bo, ~it.ao);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    // R1: reset state, inputs active
    step(8'hA5, 1, 8'h5A, 1, 0, 0, 1, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    // R3/R5: live transfer both ways
    step(8'h5A, 1, 8'hC3, 1, 0, 0, 1, 0, 0, 0, 8'h5A, 1, 8'hC3, 1, 1, "R3");
    step(8'h12, 1, 8'h34, 1, 0, 0, 1, 0, 0, 0, 8'h12, 1, 8'h34, 1, 1, "R3");
    // R2: load both registers
    step(8'h77, 1, 8'h88, 1, 0, 0, 1, 0, 1, 1, 8'h77, 1, 8'h88, 1, 1, "R2");
    // R5/R4: disabled, stored words still selected
    step(8'h11, 1, 8'h22, 1, 1, 1, 0, 1, 0, 0, 8'h77, 0, 8'h88, 0, 1, "R5");
    // R2: load while outputs disabled
    step(8'h99, 1, 8'h66, 1, 1, 1, 0, 1, 1, 1, 8'h77, 0, 8'h88, 0, 1, "R2");
    // R4: replay new words; strobe held high
    step(8'hAA, 1, 8'hBB, 1, 1, 1, 1, 0, 1, 1, 8'h99, 1, 8'h66, 1, 1, "R4");
    step(8'hCC, 1, 8'hDD, 1, 1, 1, 1, 0, 1, 1, 8'h99, 1, 8'h66, 1, 1, "R2");
    // R7: select toggles, output jumps in one cycle
    step(8'hCC, 1, 8'hDD, 1, 0, 1, 1, 0, 1, 1, 8'hCC, 1, 8'h66, 1, 1, "R7");
    step(8'hCC, 1, 8'hDD, 1, 1, 1, 1, 0, 1, 1, 8'h99, 1, 8'h66, 1, 1, "R7");
    step(8'hCC, 1, 8'hDD, 1, 0, 0, 1, 0, 1, 1, 8'hCC, 1, 8'hDD, 1, 1, "R7");
    // R8: bus hold loop (true path only)
    step(8'h3C, 1, 8'h3C, 1, 0, 0, 1, 0, 0, 0, 8'h3C, 1, 8'h3C, 1, 0, "R8");
    step(8'hFF, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0, 8'h3C, 1, 8'h3C, 1, 0, "R8");
    step(8'hFF, 0, 8'h00, 0, 0, 0, 1, 0, 0, 0, 8'h3C, 1, 8'h3C, 1, 0, "R8");
    step(8'h81, 1, 8'h00, 0, 0, 0, 1, 0, 0, 0, 8'h81, 1, 8'h3C, 1, 0, "R8");
    step(8'h81, 1, 8'h00, 0, 0, 0, 1, 0, 0, 0, 8'h81, 1, 8'h81, 1, 0, "R8");
    step(8'h00, 0, 8'hFF, 0, 0, 0, 0, 1, 0, 0, 8'h81, 0, 8'h81, 0, 0, "R8");
    step(8'h00, 0, 8'hFF, 0, 0, 0, 0, 1, 0, 0, 8'h81, 0, 8'h81, 0, 0, "R8");
    step(8'h00, 0, 8'h42, 1, 0, 0, 0, 1, 0, 0, 8'h81, 0, 8'h42, 0, 0, "R8");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule